// File: doc/BRIEF.md
# Double-Buffered Timer Compare Unit

This block is a 16-bit interval timer. It has a free-running up counter and two compare channels. Each channel holds a 16-bit compare value and sends out a one-cycle match pulse on the counting tick where the counter equals that value. Channel 1 also sets the period: on a counting tick where the counter equals the channel 1 value, the counter returns to zero. The counter therefore runs through `cmp1 + 1` counting ticks per period. The counter advances only on cycles where the external `tick` input is high and the run bit is set.

Channel 0 has a shadow register at the same byte addresses as its compare value. A control bit chooses how a write to channel 0 lands. With the bit clear, the write updates the shadow and the compare value together. With the bit set, the write updates only the shadow. The shadow is then copied into the compare value on the next counting tick that matches channel 1. Software can therefore change the channel 0 compare point at a period boundary without disturbing the period in progress.

Compare values are loaded over a byte-wide write stream. The write port follows valid/ready rules but never applies back-pressure: `wr_ready` is held high, and a byte is accepted on every cycle where `wr_valid` is high. The read port is a plain combinational lookup. Only the control register can be read back. The compare values and the shadow are write-only, and reading their addresses returns zero.

Top module: `dbuf_timer_cmp`

## Requirements
- R1: After reset, `cnt` is 0, both match outputs are 0, and the control register is 0 (stopped, shadow disabled).
- R2: On a cycle where `tick` is 1 and the run bit (control bit 0) is 1, `cnt` advances by one. On every other cycle it holds its value.
- R3: On a counting tick where `cnt` equals the channel 1 compare value, `cnt` becomes 0 instead of advancing.
- R4: `match1` is high for exactly the one cycle after a counting tick on which `cnt` equalled the channel 1 compare value. Otherwise it is low.
- R5: `match0` behaves the same way for the channel 0 compare value.
- R6: Each compare value is loaded as two bytes: a low-byte write at the even address (2 for channel 0, 4 for channel 1), then a high-byte write at the next odd address (3 or 5). Only the high-byte write changes the 16-bit value, and it combines the write data with the most recently staged low byte.
- R7: With the shadow-enable bit (control bit 1) at 0, a completed write to channel 0 updates the compare value and the shadow, effective from the next cycle.
- R8: With the shadow-enable bit at 1, a write to channel 0 updates only the shadow. The channel 0 compare value changes only on a counting tick that matches channel 1, when it takes the shadow contents.
- R9: If a shadow write and a shadow transfer fall in the same cycle, the transfer copies the shadow value from before that write. The new data moves across at the following channel 1 match.
- R10: `rd_data` returns the control register at address 0, with bit 0 as run and bit 1 as shadow enable. Every other address, including the compare and shadow addresses, reads as 0.
- R11: `wr_ready` is always 1. A write to address 0 sets run from data bit 0 and shadow enable from data bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse from an external prescaler |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte ready, held high |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write byte data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (control register only) |
| cnt | output | 16 | Current counter value |
| match0 | output | 1 | Channel 0 match pulse |
| match1 | output | 1 | Channel 1 match pulse and period boundary |

## Verification
The hardest case is a high-byte write to channel 0 that lands on the exact counting tick where the counter equals the channel 1 value while shadow mode is on. That is the only cycle in which a write and a transfer collide. The stimulus stages the low byte early. It then steps single counting ticks while tracking its own model of the counter, and issues the high-byte write on the tick whose pre-edge counter equals the channel 1 value. The effect is visible only through `match0` timing over the next two periods. For that reason the scoreboard compares every cycle of `cnt`, `match0` and `match1` against a model built from the requirements.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int CMP_W  = 2 * BYTE_W;
  localparam int N_CH   = 2;

  // Byte map: each channel occupies an even/odd pair starting at A_C0_LO.
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_C0_LO = 3'd2;

  typedef struct packed {
    logic shadow_en;  // bit 1
    logic run;        // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dbt_bus_decode.sv
module dbt_bus_decode
  import dbt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output ctrl_t                        ctrl,
  output logic [N_CH-1:0]              ld,
  output logic [N_CH-1:0][CMP_W-1:0]   ld_val,
  output logic [BYTE_W-1:0]            rd_data
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_valid && wr_addr == A_CTRL) begin
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  assign ctrl = ctrl_q;

  // Per-channel low-byte staging; the high-byte write commits the pair.
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO = A_C0_LO + ADDR_W'(2 * ch);
    localparam logic [ADDR_W-1:0] HI = LO + ADDR_W'(1);

    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
      end else if (wr_valid && wr_addr == LO) begin
        lo_q <= wr_data;
      end
    end

    assign ld[ch]     = wr_valid && (wr_addr == HI);
    assign ld_val[ch] = {wr_data, lo_q};
  end

  // Only the control register is visible to reads.
  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) begin
      rd_data[CTRL_W-1:0] = ctrl_q;
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == A_CTRL) |=> (ctrl_q == $past(wr_data[CTRL_W-1:0]))) // R11
    else $error("control write not taken");

  AST_RD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != A_CTRL) |-> (rd_data == '0)) // R10
    else $error("write-only register leaked on read");

  AST_LD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld)) // R6
    else $error("more than one channel committed");

endmodule

// File: rtl/dbt_counter.sv
module dbt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         wrap,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= wrap ? '0 : cnt_q + W'(1);
    end
  end

  assign cnt = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q)) // R2
    else $error("counter moved without a tick");

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap) |=> (cnt_q == $past(cnt_q) + W'(1))) // R2
    else $error("counter did not step by one");

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap) |=> (cnt_q == '0)) // R3
    else $error("counter did not clear at period end");

endmodule

// File: rtl/dbt_cmp_chan.sv
module dbt_cmp_chan #(
  parameter int W      = 16,
  parameter bit SHADOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         adv,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         shadow_en,
  input  logic         xfer,
  output logic         eq,
  output logic         match
);

  logic [W-1:0] cmp_q;
  logic         match_q;

  if (SHADOW) begin : g_shadow
    logic [W-1:0] shd_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_q <= '0;
      end else if (ld) begin
        shd_q <= ld_val;
      end
    end

    // Transfer reads shd_q before any same-cycle write lands in it.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q <= '0;
      end else if (shadow_en) begin
        if (xfer) cmp_q <= shd_q;
      end else if (ld) begin
        cmp_q <= ld_val;
      end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_en && !xfer) |=> $stable(cmp_q)) // R8
      else $error("compare changed outside a transfer");

    AST_SHADOW_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_en && xfer) |=> (cmp_q == $past(shd_q))) // R9
      else $error("transfer did not use the prior shadow value");

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!shadow_en && ld) |=> (cmp_q == $past(ld_val) && shd_q == $past(ld_val))) // R7
      else $error("direct write did not reach both registers");
  end else begin : g_plain
    logic unused_ctl;
    assign unused_ctl = shadow_en ^ xfer;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q <= '0;
      end else if (ld) begin
        cmp_q <= ld_val;
      end
    end
  end

  assign eq = (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else begin
      match_q <= adv && eq;
    end
  end

  assign match = match_q;

  AST_MATCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> $past(adv)) // R4
    else $error("match pulse without a counting tick");

  AST_MATCH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && eq) |=> match_q) // R5
    else $error("equality on a tick produced no pulse");

endmodule

// File: rtl/dbuf_timer_cmp.sv
module dbuf_timer_cmp
  import dbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CMP_W-1:0]  cnt,
  output logic              match0,
  output logic              match1
);

  ctrl_t                       ctrl;
  logic [N_CH-1:0]             ld;
  logic [N_CH-1:0][CMP_W-1:0]  ld_val;
  logic [N_CH-1:0]             eq;
  logic [N_CH-1:0]             match;
  logic                        adv;
  logic                        xfer;

  assign wr_ready = 1'b1;
  assign adv      = tick && ctrl.run;
  assign xfer     = adv && eq[1];

  dbt_bus_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .ctrl     (ctrl),
    .ld       (ld),
    .ld_val   (ld_val),
    .rd_data  (rd_data)
  );

  dbt_counter #(.W(CMP_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .wrap  (eq[1]),
    .cnt   (cnt)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    dbt_cmp_chan #(.W(CMP_W), .SHADOW(ch == 0)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .adv       (adv),
      .ld        (ld[ch]),
      .ld_val    (ld_val[ch]),
      .shadow_en (ctrl.shadow_en),
      .xfer      (xfer),
      .eq        (eq[ch]),
      .match     (match[ch])
    );
  end

  assign match0 = match[0];
  assign match1 = match[1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && !match0 && !match1)) // R1
    else $error("outputs not cleared by reset");

endmodule

// File: tb/dbuf_timer_cmp_bench.sv
`timescale 1ns/1ps
module dbuf_timer_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] cnt;
  logic        match0, match1;

  always #2 clk = ~clk;

  dbuf_timer_cmp u_dbuf_timer_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt(cnt), .match0(match0), .match1(match1)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Scoreboard queue of expected {cnt, match0, match1}.
  logic [17:0] expq[$];

  // Requirement model state.
  logic [15:0] m_cnt = '0, m_cmp0 = '0, m_cmp1 = '0, m_shd = '0;
  logic [7:0]  m_lo0 = '0, m_lo1 = '0;
  logic        m_run = 1'b0, m_shen = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per driven cycle.
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [17:0] e;
      e = expq.pop_front();
      chk("R2/R3 cnt", {16'd0, cnt}, {16'd0, e[17:2]});
      chk("R5/R7/R8/R9 match0", {31'd0, match0}, {31'd0, e[1]});
      chk("R4 match1", {31'd0, match1}, {31'd0, e[0]});
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic tk, input logic wv, input logic [2:0] a, input logic [7:0] d);
    logic ct, e0, e1, os;
    logic [15:0] ob;
    logic m0, m1;
    tick = tk; wr_valid = wv; wr_addr = a; wr_data = d;
    @(posedge clk);
    ct = tk && m_run;
    e0 = (m_cnt == m_cmp0);
    e1 = (m_cnt == m_cmp1);
    ob = m_shd;
    os = m_shen;
    m0 = ct && e0;
    m1 = ct && e1;
    if (ct) m_cnt = e1 ? 16'd0 : m_cnt + 16'd1;
    if (ct && e1 && os) m_cmp0 = ob;
    if (wv) begin
      case (a)
        3'd0: begin m_run = d[0]; m_shen = d[1]; end
        3'd2: m_lo0 = d;
        3'd3: begin m_shd = {d, m_lo0}; if (!os) m_cmp0 = {d, m_lo0}; end
        3'd4: m_lo1 = d;
        3'd5: m_cmp1 = {d, m_lo1};
        default: ;
      endcase
    end
    expq.push_back({m_cnt, m0, m1});
    #1;
    tick = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    step(1'b0, 1'b1, lo, v[7:0]);            // R6 low byte staged
    step(1'b0, 1'b1, lo + 3'd1, v[15:8]);    // R6 high byte commits
  endtask

  task automatic run_ticks(input int n, input int every);
    for (int i = 0; i < n; i++) step((i % every) == 0, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic check_reads();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.5;
      chk("R10 rd_data", {24'd0, rd_data}, (a == 0) ? {30'd0, m_shen, m_run} : 32'd0);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cnt", {16'd0, cnt}, 32'd0);
    chk("R1 match0", {31'd0, match0}, 32'd0);
    chk("R1 match1", {31'd0, match1}, 32'd0);
    rd_addr = 3'd0; #0.5;
    chk("R1 ctrl", {24'd0, rd_data}, 32'd0);
    chk("R11 wr_ready", {31'd0, wr_ready}, 32'd1);
    rst_n = 1'b1;

    // Load all compare registers before starting.
    wr16(3'd4, 16'd9);
    wr16(3'd2, 16'd4);
    run_ticks(5, 1);                          // R2: stopped, no count
    step(1'b0, 1'b1, 3'd0, 8'h01);            // R11 run on
    run_ticks(40, 1);
    run_ticks(45, 3);

    // R6: low byte alone has no effect.
    step(1'b0, 1'b1, 3'd2, 8'h06);
    run_ticks(30, 1);
    step(1'b0, 1'b1, 3'd3, 8'h00);
    run_ticks(30, 1);

    // R2: stop holds the counter.
    step(1'b0, 1'b1, 3'd0, 8'h00);
    run_ticks(10, 1);

    // R8: shadow mode, write waits for period boundary.
    step(1'b0, 1'b1, 3'd0, 8'h03);
    check_reads();                            // R10
    wr16(3'd2, 16'd2);
    run_ticks(30, 1);

    // R9: collide a shadow write with a transfer.
    step(1'b0, 1'b1, 3'd2, 8'h08);
    while (m_cnt != m_cmp1) step(1'b1, 1'b0, 3'd0, 8'd0);
    step(1'b1, 1'b1, 3'd3, 8'h00);
    run_ticks(25, 1);

    // R7: back to direct writes.
    step(1'b0, 1'b1, 3'd0, 8'h01);
    check_reads();                            // R10
    wr16(3'd2, 16'd3);
    run_ticks(30, 1);

    // Short period, sparse ticks.
    wr16(3'd4, 16'd3);
    wr16(3'd2, 16'd1);
    run_ticks(40, 2);

    // Period 1: channel 1 at zero.
    wr16(3'd4, 16'd0);
    run_ticks(8, 1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule